// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two ports, each running on its own clock, a way to pass single 36-bit words to each other without going through the main data queue. Port A deposits words into mailbox 1 and collects words from mailbox 2. Port B deposits into mailbox 2 and collects from mailbox 1. Every port has a clock, a synchronous active-high reset, an active-low chip select, an enable, a direction input and a mailbox select. The direction input has opposite senses on the two ports.

Each mailbox keeps an active-low "mail present" indication. It is visible in both domains: a writer-side copy and a reader-side copy. A write lowers the writer-side copy at once. That event travels to the reader's domain through a toggle handshake and lowers the reader-side copy. A read in the reader's domain raises the reader-side copy at once. The consumption travels back and raises the writer-side copy. The stored word is held in a register clocked by the writer. While the word is announced it does not change unless the writer overwrites it, so the reader takes it without a data synchronizer.

Port B has a registered output that shows either mailbox 1 or the word offered by the external queue, chosen by port B's mailbox select. Port A has a registered output that shows mailbox 2. Each port has an output-enable flag that is high while that port is selected for reading.

Top module: `mbx_pair`

## Requirements
- R1: A port transfer happens only on a rising edge of that port's clock where chip select is 0 and enable is 1. With enable at 0 or chip select at 1, no flag changes and no mailbox word changes.
- R2: On port A, a direction input of 1 means write and 0 means read. On port B, 0 means write and 1 means read.
- R3: A transfer with mailbox select at 0 leaves both mailboxes untouched. It is neither a mailbox write nor a mailbox read.
- R4: A port-A mailbox write stores the word in mailbox 1. On that port-A edge it drives `mb1_flag_a_n` to 0. `mb1_flag_b_n` goes to 0 within 4 port-B clock cycles.
- R5: A port-B mailbox read while `mb1_flag_b_n` is 0 drives `mb1_flag_b_n` to 1 on that port-B edge. `mb1_flag_a_n` returns to 1 within 4 port-A clock cycles.
- R6: Mailbox 2 behaves in the mirrored way. A port-B mailbox write drives `mb2_flag_b_n` to 0 on that edge, and `mb2_flag_a_n` follows within 4 port-A cycles. A port-A mailbox read while `mb2_flag_a_n` is 0 drives `mb2_flag_a_n` to 1 on that edge, and `mb2_flag_b_n` follows within 4 port-B cycles.
- R7: While its reset is high, each domain holds its two flags at 1, its output-enable at 0 and its data output at 0.
- R8: A second write to a full mailbox replaces the held word and keeps the flags at 0. A single read then empties the mailbox in both domains, and no further mail is announced.
- R9: One port-B cycle after an edge, `b_dout` shows mailbox 1 if `b_mbx_sel` was 1 and `b_fifo_rdata` if it was 0. `b_dout_oe` is 1 exactly when chip select was 0 and direction was 1. The port-A side works the same way: `a_dout` shows mailbox 2, and `a_dout_oe` follows chip select 0 with direction 0.
- R10: A mailbox read while the mailbox is empty has no effect. Both flags stay at 1, and a later write is announced normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port-A clock |
| rst_a | input | 1 | Port-A synchronous reset, active high |
| a_cs_n | input | 1 | Port-A chip select, active low |
| a_en | input | 1 | Port-A transfer enable |
| a_wr_rd | input | 1 | Port-A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port-A mailbox select |
| a_din | input | 36 | Port-A write word |
| a_dout | output | 36 | Port-A registered read word (mailbox 2) |
| a_dout_oe | output | 1 | Port-A output drive flag |
| mb1_flag_a_n | output | 1 | Mailbox 1 full, port-A copy, active low |
| mb2_flag_a_n | output | 1 | Mailbox 2 full, port-A copy, active low |
| clk_b | input | 1 | Port-B clock |
| rst_b | input | 1 | Port-B synchronous reset, active high |
| b_cs_n | input | 1 | Port-B chip select, active low |
| b_en | input | 1 | Port-B transfer enable |
| b_wr_rd | input | 1 | Port-B direction: 0 write, 1 read |
| b_mbx_sel | input | 1 | Port-B mailbox select / output mux select |
| b_din | input | 36 | Port-B write word |
| b_fifo_rdata | input | 36 | Word offered by the external queue |
| b_dout | output | 36 | Port-B registered read word |
| b_dout_oe | output | 1 | Port-B output drive flag |
| mb1_flag_b_n | output | 1 | Mailbox 1 full, port-B copy, active low |
| mb2_flag_b_n | output | 1 | Mailbox 2 full, port-B copy, active low |

## Verification
On every edge the assertions check the local flag actions in each domain: a decoded mailbox write lowers the writer-side flag, and a decoded read of a full mailbox raises the reader-side flag. They also check that these flags move only for those causes, that reset holds the flags high, and that port B's output-enable follows its select and direction. The bench scenarios are needed for everything that crosses domains. These are the remote flag following within the stated cycle count, the data seen by the reader matching what the writer stored, overwrite behaviour, reads of an empty mailbox, and the port-B output mux choosing between mailbox and queue data.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Decoded action of one port for the current clock edge
  typedef struct packed {
    logic mb_wr;   // write into this port's outgoing mailbox
    logic mb_rd;   // read from this port's incoming mailbox
    logic drive;   // port is selected for reading (outputs driven)
  } port_op_t;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter bit WRITE_LEVEL = 1'b1
) (
  input  logic              cs_n,
  input  logic              en,
  input  logic              wr_rd,
  input  logic              mb_sel,
  output mbx_pkg::port_op_t op
);

  logic xfer;
  logic is_wr;

  always_comb begin
    xfer     = !cs_n && en;
    is_wr    = (wr_rd == WRITE_LEVEL);
    op.mb_wr = xfer && is_wr && mb_sel;
    op.mb_rd = xfer && !is_wr && mb_sel;
    op.drive = !cs_n && !is_wr;
  end

endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              w_clk,
  input  logic              w_rst,
  input  logic              w_en,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_flag_n,
  input  logic              r_clk,
  input  logic              r_rst,
  input  logic              r_en,
  output logic              r_flag_n,
  output logic [DATA_W-1:0] q_data
);

  // writer domain state
  logic              w_tog;
  logic              w_seen;
  logic              r_tog_s;
  logic              w_clr;
  logic [DATA_W-1:0] hold;

  // reader domain state
  logic r_tog;
  logic r_seen;
  logic w_tog_s;
  logic r_new;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_rd_to_wr (
    .clk(w_clk), .rst(w_rst), .d(r_tog), .q(r_tog_s)
  );

  mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_to_rd (
    .clk(r_clk), .rst(r_rst), .d(w_tog), .q(w_tog_s)
  );

  assign w_clr = r_tog_s ^ w_seen;
  assign r_new = w_tog_s ^ r_seen;

  // Writer: store the word, announce it once per empty-to-full change
  always_ff @(posedge w_clk) begin
    if (w_rst) begin
      w_tog    <= 1'b0;
      w_seen   <= 1'b0;
      w_flag_n <= 1'b1;
      hold     <= '0;
    end else begin
      w_seen <= r_tog_s;
      if (w_en) begin
        hold     <= w_data;
        w_flag_n <= 1'b0;
        if (w_flag_n || w_clr) w_tog <= ~w_tog;
      end else if (w_clr) begin
        w_flag_n <= 1'b1;
      end
    end
  end

  // Reader: see the announcement, consume on a read of a full mailbox
  always_ff @(posedge r_clk) begin
    if (r_rst) begin
      r_tog    <= 1'b0;
      r_seen   <= 1'b0;
      r_flag_n <= 1'b1;
    end else begin
      r_seen <= w_tog_s;
      if (r_new) begin
        r_flag_n <= 1'b0;
      end else if (r_en && !r_flag_n) begin
        r_flag_n <= 1'b1;
        r_tog    <= ~r_tog;
      end
    end
  end

  assign q_data = hold;

endmodule

// File: rtl/mbx_pair.sv
module mbx_pair #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              a_cs_n,
  input  logic              a_en,
  input  logic              a_wr_rd,
  input  logic              a_mbx_sel,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_dout_oe,
  output logic              mb1_flag_a_n,
  output logic              mb2_flag_a_n,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              b_cs_n,
  input  logic              b_en,
  input  logic              b_wr_rd,
  input  logic              b_mbx_sel,
  input  logic [DATA_W-1:0] b_din,
  input  logic [DATA_W-1:0] b_fifo_rdata,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_dout_oe,
  output logic              mb1_flag_b_n,
  output logic              mb2_flag_b_n
);

  localparam int NUM_MBX = 2;

  mbx_pkg::port_op_t op_a;
  mbx_pkg::port_op_t op_b;

  mbx_port_dec #(.WRITE_LEVEL(1'b1)) u_dec_a (
    .cs_n(a_cs_n), .en(a_en), .wr_rd(a_wr_rd), .mb_sel(a_mbx_sel), .op(op_a)
  );

  mbx_port_dec #(.WRITE_LEVEL(1'b0)) u_dec_b (
    .cs_n(b_cs_n), .en(b_en), .wr_rd(b_wr_rd), .mb_sel(b_mbx_sel), .op(op_b)
  );

  // index 0: mailbox 1 (A writes, B reads); index 1: mailbox 2 (B writes, A reads)
  logic [NUM_MBX-1:0] s_wclk, s_rclk, s_wrst, s_rrst, s_wen, s_ren;
  logic [NUM_MBX-1:0] s_wflag, s_rflag;
  logic [DATA_W-1:0]  s_wdat [NUM_MBX];
  logic [DATA_W-1:0]  s_q    [NUM_MBX];

  assign s_wclk    = {clk_b, clk_a};
  assign s_rclk    = {clk_a, clk_b};
  assign s_wrst    = {rst_b, rst_a};
  assign s_rrst    = {rst_a, rst_b};
  assign s_wen     = {op_b.mb_wr, op_a.mb_wr};
  assign s_ren     = {op_a.mb_rd, op_b.mb_rd};
  assign s_wdat[0] = a_din;
  assign s_wdat[1] = b_din;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_slot
    mbx_slot #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slot (
      .w_clk   (s_wclk[i]),
      .w_rst   (s_wrst[i]),
      .w_en    (s_wen[i]),
      .w_data  (s_wdat[i]),
      .w_flag_n(s_wflag[i]),
      .r_clk   (s_rclk[i]),
      .r_rst   (s_rrst[i]),
      .r_en    (s_ren[i]),
      .r_flag_n(s_rflag[i]),
      .q_data  (s_q[i])
    );
  end

  assign mb1_flag_a_n = s_wflag[0];
  assign mb1_flag_b_n = s_rflag[0];
  assign mb2_flag_b_n = s_wflag[1];
  assign mb2_flag_a_n = s_rflag[1];

  // Port-A registered output
  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      a_dout    <= '0;
      a_dout_oe <= 1'b0;
    end else begin
      a_dout    <= s_q[1];
      a_dout_oe <= op_a.drive;
    end
  end

  // Port-B registered output with mailbox / queue selection
  always_ff @(posedge clk_b) begin
    if (rst_b) begin
      b_dout    <= '0;
      b_dout_oe <= 1'b0;
    end else begin
      b_dout    <= b_mbx_sel ? s_q[0] : b_fifo_rdata;
      b_dout_oe <= op_b.drive;
    end
  end

endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk (
  input logic clk_a,
  input logic rst_a,
  input logic a_cs_n,
  input logic a_en,
  input logic a_wr_rd,
  input logic a_mbx_sel,
  input logic mb1_flag_a_n,
  input logic mb2_flag_a_n,
  input logic clk_b,
  input logic rst_b,
  input logic b_cs_n,
  input logic b_en,
  input logic b_wr_rd,
  input logic b_mbx_sel,
  input logic b_dout_oe,
  input logic mb1_flag_b_n,
  input logic mb2_flag_b_n
);

  logic a_put, a_take, b_put, b_take;
  assign a_put  = !a_cs_n && a_en &&  a_wr_rd && a_mbx_sel;
  assign a_take = !a_cs_n && a_en && !a_wr_rd && a_mbx_sel;
  assign b_put  = !b_cs_n && b_en && !b_wr_rd && b_mbx_sel;
  assign b_take = !b_cs_n && b_en &&  b_wr_rd && b_mbx_sel;

  // R4
  mb1_set_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    a_put |=> !mb1_flag_a_n);

  // R1
  mb1_set_cause_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(mb1_flag_a_n) |-> $past(a_put));

  // R5
  mb1_clear_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_take && !mb1_flag_b_n) |=> mb1_flag_b_n);

  // R10
  mb1_clear_cause_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    $rose(mb1_flag_b_n) |-> $past(b_take));

  // R6
  mb2_set_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    b_put |=> !mb2_flag_b_n);

  // R6
  mb2_clear_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_take && !mb2_flag_a_n) |=> mb2_flag_a_n);

  // R7
  reset_a_flags_chk: assert property (@(posedge clk_a)
    rst_a |=> (mb1_flag_a_n && mb2_flag_a_n));

  // R7
  reset_b_flags_chk: assert property (@(posedge clk_b)
    rst_b |=> (mb1_flag_b_n && mb2_flag_b_n));

  // R9
  b_oe_on_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    (!b_cs_n && b_wr_rd) |=> b_dout_oe);

  // R9
  b_oe_off_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    !(!b_cs_n && b_wr_rd) |=> !b_dout_oe);

endmodule

bind mbx_pair mbx_pair_chk u_chk (
  .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_en(a_en),
  .a_wr_rd(a_wr_rd), .a_mbx_sel(a_mbx_sel),
  .mb1_flag_a_n(mb1_flag_a_n), .mb2_flag_a_n(mb2_flag_a_n),
  .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_en(b_en),
  .b_wr_rd(b_wr_rd), .b_mbx_sel(b_mbx_sel), .b_dout_oe(b_dout_oe),
  .mb1_flag_b_n(mb1_flag_b_n), .mb2_flag_b_n(mb2_flag_b_n)
);

// File: tb/tb_mbx_pair.sv
module tb_mbx_pair;

  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a, rst_b;
  logic a_cs_n, a_en, a_wr_rd, a_mbx_sel;
  logic b_cs_n, b_en, b_wr_rd, b_mbx_sel;
  logic [W-1:0] a_din, b_din, b_fifo_rdata;
  logic [W-1:0] a_dout, b_dout;
  logic a_dout_oe, b_dout_oe;
  logic mb1_flag_a_n, mb2_flag_a_n, mb1_flag_b_n, mb2_flag_b_n;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk_a = ~clk_a;   // 125 MHz
  always #5 clk_b = ~clk_b;

  mbx_pair dut (
    .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_en(a_en),
    .a_wr_rd(a_wr_rd), .a_mbx_sel(a_mbx_sel), .a_din(a_din),
    .a_dout(a_dout), .a_dout_oe(a_dout_oe),
    .mb1_flag_a_n(mb1_flag_a_n), .mb2_flag_a_n(mb2_flag_a_n),
    .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_en(b_en),
    .b_wr_rd(b_wr_rd), .b_mbx_sel(b_mbx_sel), .b_din(b_din),
    .b_fifo_rdata(b_fifo_rdata), .b_dout(b_dout), .b_dout_oe(b_dout_oe),
    .mb1_flag_b_n(mb1_flag_b_n), .mb2_flag_b_n(mb2_flag_b_n)
  );

  // bit 36: 0 = port A to port B through mailbox 1, 1 = port B to port A through mailbox 2
  localparam logic [W:0] VEC [6] = '{
    {1'b0, 36'h1_2345_6789},
    {1'b1, 36'hF_EDCB_A987},
    {1'b0, 36'h0_0000_0000},
    {1'b1, 36'hF_FFFF_FFFF},
    {1'b0, 36'hA_5A5A_5A5A},
    {1'b1, 36'h5_A5A5_A5A5}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic cs_n, input logic en, input logic wr,
                      input logic sel, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs_n = cs_n; a_en = en; a_wr_rd = wr; a_mbx_sel = sel; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1'b1; a_en = 1'b0; a_wr_rd = 1'b0; a_mbx_sel = 1'b0;
  endtask

  task automatic b_op(input logic cs_n, input logic en, input logic wr,
                      input logic sel, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs_n = cs_n; b_en = en; b_wr_rd = wr; b_mbx_sel = sel; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1'b1; b_en = 1'b0; b_wr_rd = 1'b0; b_mbx_sel = 1'b0;
  endtask

  task automatic a_wait(input int n);
    repeat (n) @(negedge clk_a);
  endtask

  task automatic b_wait(input int n);
    repeat (n) @(negedge clk_b);
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    rst_a = 1'b1; rst_b = 1'b1;
    a_cs_n = 1'b1; a_en = 1'b0; a_wr_rd = 1'b0; a_mbx_sel = 1'b0; a_din = '0;
    b_cs_n = 1'b1; b_en = 1'b0; b_wr_rd = 1'b0; b_mbx_sel = 1'b0; b_din = '0;
    b_fifo_rdata = 36'h3_1415_9265;

    a_wait(5);
    b_wait(5);
    // R7: reset state
    check("R7 mb1_flag_a_n", mb1_flag_a_n, 1);
    check("R7 mb2_flag_a_n", mb2_flag_a_n, 1);
    check("R7 mb1_flag_b_n", mb1_flag_b_n, 1);
    check("R7 mb2_flag_b_n", mb2_flag_b_n, 1);
    check("R7 a_dout_oe", a_dout_oe, 0);
    check("R7 b_dout_oe", b_dout_oe, 0);
    check("R7 a_dout", a_dout, 0);
    check("R7 b_dout", b_dout, 0);
    @(negedge clk_a); rst_a = 1'b0;
    @(negedge clk_b); rst_b = 1'b0;
    a_wait(3);

    // table of transfers
    for (int i = 0; i < 6; i++) begin
      d = VEC[i][W-1:0];
      if (!VEC[i][W]) begin
        a_op(0, 1, 1, 1, d);
        check("R4 mb1 writer flag low", mb1_flag_a_n, 0);
        b_wait(5);
        check("R4 mb1 reader flag low", mb1_flag_b_n, 0);
        b_op(0, 0, 1, 1, '0);
        check("R9 b_dout mailbox word", b_dout, d);
        check("R9 b_dout_oe on read select", b_dout_oe, 1);
        check("R1 enable low keeps mb1 full", mb1_flag_b_n, 0);
        b_op(0, 1, 1, 1, '0);
        check("R5 mb1 reader flag high", mb1_flag_b_n, 1);
        a_wait(5);
        check("R5 mb1 writer flag high", mb1_flag_a_n, 1);
      end else begin
        b_op(0, 1, 0, 1, d);
        check("R6 mb2 writer flag low", mb2_flag_b_n, 0);
        a_wait(5);
        check("R6 mb2 reader flag low", mb2_flag_a_n, 0);
        a_op(0, 0, 0, 1, '0);
        check("R9 a_dout mailbox word", a_dout, d);
        check("R9 a_dout_oe on read select", a_dout_oe, 1);
        a_op(0, 1, 0, 1, '0);
        check("R6 mb2 reader flag high", mb2_flag_a_n, 1);
        b_wait(5);
        check("R6 mb2 writer flag high", mb2_flag_b_n, 1);
      end
    end

    // R1: enable low, then chip select high: ignored
    a_op(0, 0, 1, 1, 36'h9_9999_9999);
    a_op(1, 1, 1, 1, 36'h8_8888_8888);
    check("R1 ignored write mb1_flag_a_n", mb1_flag_a_n, 1);
    b_wait(5);
    check("R1 ignored write mb1_flag_b_n", mb1_flag_b_n, 1);
    b_op(0, 0, 1, 1, '0);
    check("R1 ignored write keeps mb1 word", b_dout, 36'hA_5A5A_5A5A);

    // R3: mailbox select low is no mailbox write
    a_op(0, 1, 1, 0, 36'h7_7777_7777);
    check("R3 select low mb1_flag_a_n", mb1_flag_a_n, 1);
    b_wait(5);
    check("R3 select low mb1_flag_b_n", mb1_flag_b_n, 1);
    b_op(0, 0, 1, 1, '0);
    check("R3 select low keeps mb1 word", b_dout, 36'hA_5A5A_5A5A);

    // R2: port-A direction 0 and port-B direction 1 are reads, not writes
    a_op(0, 1, 0, 1, 36'h6_6666_6666);
    b_op(0, 1, 1, 1, 36'h6_6666_6666);
    a_wait(5);
    b_wait(5);
    check("R2 A read sense: mb1_flag_b_n", mb1_flag_b_n, 1);
    check("R2 B read sense: mb2_flag_a_n", mb2_flag_a_n, 1);
    a_op(0, 0, 0, 1, '0);
    check("R2 mb2 word unchanged", a_dout, 36'h5_A5A5_A5A5);

    // R10: read of empty mailbox has no effect; later write works
    b_op(0, 1, 1, 1, '0);
    check("R10 empty read mb1_flag_b_n", mb1_flag_b_n, 1);
    a_wait(5);
    check("R10 empty read mb1_flag_a_n", mb1_flag_a_n, 1);
    a_op(0, 1, 1, 1, 36'h2_2222_2222);
    b_wait(5);
    check("R10 write after empty read announced", mb1_flag_b_n, 0);
    b_op(0, 1, 1, 1, '0);
    a_wait(5);

    // R8: overwrite while full
    a_op(0, 1, 1, 1, 36'hC_0000_0001);
    a_op(0, 1, 1, 1, 36'hC_0000_0002);
    check("R8 overwrite mb1_flag_a_n", mb1_flag_a_n, 0);
    b_wait(5);
    check("R8 overwrite mb1_flag_b_n", mb1_flag_b_n, 0);
    b_op(0, 0, 1, 1, '0);
    check("R8 overwrite shows second word", b_dout, 36'hC_0000_0002);
    b_op(0, 1, 1, 1, '0);
    check("R8 one read empties reader side", mb1_flag_b_n, 1);
    a_wait(5);
    check("R8 one read empties writer side", mb1_flag_a_n, 1);
    b_wait(5);
    check("R8 no extra mail announced", mb1_flag_b_n, 1);

    // R9: output mux and output-enable
    b_op(0, 0, 1, 0, '0);
    check("R9 select low shows queue word", b_dout, 36'h3_1415_9265);
    check("R9 oe on read", b_dout_oe, 1);
    b_op(0, 0, 0, 1, '0);
    check("R9 oe off on write sense", b_dout_oe, 0);
    b_op(1, 0, 1, 1, '0);
    check("R9 oe off when deselected", b_dout_oe, 0);

    // R3: port-B read with select low does not consume mailbox 1
    a_op(0, 1, 1, 1, 36'h4_4444_4444);
    b_wait(5);
    b_op(0, 1, 1, 0, '0);
    check("R3 queue read leaves mb1 full", mb1_flag_b_n, 0);
    b_op(0, 1, 1, 1, '0);
    check("R5 mailbox read empties mb1", mb1_flag_b_n, 1);
    a_wait(5);
    check("R5 writer side clears", mb1_flag_a_n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule